// File: doc/BRIEF.md
# Dual-Format Stereo Audio Serial Receiver

This block is the slave side of a three-wire stereo audio link. It is clocked by the link's bit clock. On every rising edge it samples the frame (left/right) clock and the serial data line. It rebuilds two signed 24-bit channel words and hands each finished left/right pair to the rest of the chip on a parallel bus, together with a one-cycle valid strobe. A static format input picks the framing at run time. In left-justified framing the first bit after a frame-clock change is the MSB. In I2S framing the MSB comes one bit later and the channel polarity of the frame clock is inverted.

Each change of the frame clock closes the current channel slot and opens the next one. Slots may be longer or shorter than the 24-bit word. Extra bits are ignored and missing low bits read as zero.

A silence monitor watches the completed pairs. It raises a flag once a programmable number of consecutive pairs (8192 by default) have both channels exactly zero. It drops the flag as soon as any slot closes with a nonzero word.

Top module: `aud_rx`

## Requirements
- R1: Data is sampled on the rising bit-clock edge, most significant bit first, and presented as a 24-bit two's-complement word whose bit 23 is the first data bit of the slot.
- R2: With `fmt_i` = 0 (left-justified), bit 23 is the data value sampled on the first rising edge at which `frame_i` differs from its previous sample, and a slot with `frame_i` = 1 carries the left channel.
- R3: With `fmt_i` = 1 (I2S), bit 23 is sampled one edge after the frame-clock change, and a slot with `frame_i` = 0 carries the left channel. The last bit of a 24-edge slot is taken on the edge that starts the next slot.
- R4: Data bits beyond the 24th in a slot have no effect on the output words.
- R5: On the rising edge that ends a right slot which followed a completed left slot, `left_o`/`right_o` load the pair and `valid_o` is high for exactly that one cycle. Between such edges the outputs hold their values.
- R6: A slot with fewer than 24 data bits delivers its received bits in the top positions and zeros in the remaining low positions.
- R7: `zero_o` rises on the same edge that presents the ZERO_RUN-th consecutive pair in which both words are zero (ZERO_RUN defaults to 8192).
- R8: `zero_o` falls on the edge that closes any slot, left or right, whose word is nonzero. A zero left slot leaves it unchanged.
- R9: While `rst_ni` is low all outputs are zero. The slot in progress when reset is released is discarded, and a right slot with no completed left slot before it produces no valid strobe.
- R10: Every change of `frame_i` restarts the bit position, so slot lengths may differ from slot to slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk_i | input | 1 | Bit clock; all state updates on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fmt_i | input | 1 | Framing select: 0 left-justified, 1 I2S |
| frame_i | input | 1 | Frame (channel select) clock |
| sdata_i | input | 1 | Serial data line |
| left_o | output | 24 | Left word of the last completed pair |
| right_o | output | 24 | Right word of the last completed pair |
| valid_o | output | 1 | One-cycle strobe for a new pair |
| zero_o | output | 1 | Both channels have been zero for ZERO_RUN pairs |

## Verification
The pair strobe and a change of the silence flag can fall on the same bit-clock edge. The flag rises on the very edge that presents the threshold pair, and it falls on the edge that presents a pair with a nonzero right word. The bench provokes both cases with a reduced ZERO_RUN. It feeds a run of all-zero pairs up to the threshold, then a pair whose right word alone is nonzero. At the snapshot taken just after each slot-opening edge, it checks `valid_o`, the words and `zero_o` together. A separate step closes a nonzero left slot and shows that the flag drops there with no strobe.

// File: rtl/aud_rx_pkg.sv
`timescale 1ns/1ps
package aud_rx_pkg;

    typedef enum logic {
        FMT_LEFT_JUST = 1'b0,
        FMT_I2S       = 1'b1
    } aud_fmt_e;

endpackage

// File: rtl/aud_rx_slot.sv
`timescale 1ns/1ps
module aud_rx_slot
    import aud_rx_pkg::*;
#(
    parameter int WORD = 24
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            fmt_i,
    input  logic            frame_i,
    input  logic            sdata_i,
    output logic            done_o,
    output logic            left_o,
    output logic [WORD-1:0] word_o
);

    localparam int                POS_W   = $clog2(WORD + 2);
    localparam logic [POS_W-1:0]  POS_MAX = POS_W'(WORD + 1);
    localparam logic [WORD-1:0]   MSB_ONE = {1'b1, {(WORD-1){1'b0}}};

    typedef struct packed {
        logic             frame;
        logic             armed;
        logic [POS_W-1:0] pos;
        logic [WORD-1:0]  word;
    } slot_st_t;

    aud_fmt_e         fmt;
    slot_st_t         st_d, st_q;
    logic [WORD-1:0]  fin_d;
    logic             done_d;
    logic [WORD-1:0]  bit_m;
    logic [POS_W-1:0] idx;

    assign fmt = aud_fmt_e'(fmt_i);

    always_comb begin
        st_d       = st_q;
        fin_d      = st_q.word;
        done_d     = 1'b0;
        bit_m      = '0;
        idx        = '0;
        st_d.frame = frame_i;
        if (frame_i != st_q.frame) begin
            // slot boundary: close the old slot, open a new one
            if (fmt == FMT_I2S) begin
                bit_m = MSB_ONE >> st_q.pos;
                fin_d = sdata_i ? (fin_d | bit_m) : (fin_d & ~bit_m);
            end
            done_d     = st_q.armed;
            st_d.armed = 1'b1;
            st_d.pos   = '0;
            st_d.word  = '0;
            if (fmt == FMT_LEFT_JUST) begin
                st_d.word = sdata_i ? MSB_ONE : '0;
            end
        end else begin
            if (st_q.pos != POS_MAX) begin
                st_d.pos = st_q.pos + 1'b1;
            end
            idx       = st_d.pos - POS_W'(fmt == FMT_I2S);
            bit_m     = MSB_ONE >> idx;
            st_d.word = sdata_i ? (st_q.word | bit_m) : (st_q.word & ~bit_m);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o = done_d;
    assign left_o = st_q.frame ^ fmt_i;
    assign word_o = fin_d;

    AST_DONE_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (frame_i != $past(frame_i))); // R10

endmodule

// File: rtl/aud_rx_pair.sv
`timescale 1ns/1ps
module aud_rx_pair #(
    parameter int WORD = 24
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            done_i,
    input  logic            left_i,
    input  logic [WORD-1:0] word_i,
    output logic [WORD-1:0] left_o,
    output logic [WORD-1:0] right_o,
    output logic            valid_o
);

    typedef struct packed {
        logic [WORD-1:0] hold;
        logic            have;
        logic [WORD-1:0] lword;
        logic [WORD-1:0] rword;
        logic            valid;
    } pair_st_t;

    pair_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (done_i) begin
            if (left_i) begin
                st_d.hold = word_i;
                st_d.have = 1'b1;
            end else if (st_q.have) begin
                st_d.lword = st_q.hold;
                st_d.rword = word_i;
                st_d.valid = 1'b1;
                st_d.have  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign left_o  = st_q.lword;
    assign right_o = st_q.rword;
    assign valid_o = st_q.valid;

    AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |=> !valid_o); // R5
    AST_PAIR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_o |-> ($stable(left_o) && $stable(right_o))); // R5

endmodule

// File: rtl/aud_rx_zero.sv
`timescale 1ns/1ps
module aud_rx_zero #(
    parameter int WORD     = 24,
    parameter int ZERO_RUN = 8192
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            done_i,
    input  logic            left_i,
    input  logic [WORD-1:0] word_i,
    output logic            zero_o
);

    localparam int              CNT_W   = $clog2(ZERO_RUN + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(ZERO_RUN);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             lz;
        logic             flag;
    } zero_st_t;

    zero_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (done_i) begin
            if (word_i != '0) begin
                st_d.cnt  = '0;
                st_d.lz   = 1'b0;
                st_d.flag = 1'b0;
            end else if (left_i) begin
                st_d.lz = 1'b1;
            end else begin
                if (st_q.lz && (st_q.cnt != CNT_TOP)) begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
                st_d.lz   = 1'b0;
                st_d.flag = (st_d.cnt == CNT_TOP);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign zero_o = st_q.flag;

    AST_ZERO_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_i && (word_i != '0)) |=> !zero_o); // R8
    AST_ZERO_RISE_RIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(zero_o) |-> $past(done_i && !left_i)); // R7

endmodule

// File: rtl/aud_rx.sv
`timescale 1ns/1ps
module aud_rx #(
    parameter int WORD     = 24,
    parameter int ZERO_RUN = 8192
) (
    input  logic            bclk_i,
    input  logic            rst_ni,
    input  logic            fmt_i,
    input  logic            frame_i,
    input  logic            sdata_i,
    output logic [WORD-1:0] left_o,
    output logic [WORD-1:0] right_o,
    output logic            valid_o,
    output logic            zero_o
);

    logic            slot_done;
    logic            slot_left;
    logic [WORD-1:0] slot_word;

    aud_rx_slot #(.WORD(WORD)) u_slot (
        .clk_i   (bclk_i),
        .rst_ni  (rst_ni),
        .fmt_i   (fmt_i),
        .frame_i (frame_i),
        .sdata_i (sdata_i),
        .done_o  (slot_done),
        .left_o  (slot_left),
        .word_o  (slot_word)
    );

    aud_rx_pair #(.WORD(WORD)) u_pair (
        .clk_i   (bclk_i),
        .rst_ni  (rst_ni),
        .done_i  (slot_done),
        .left_i  (slot_left),
        .word_i  (slot_word),
        .left_o  (left_o),
        .right_o (right_o),
        .valid_o (valid_o)
    );

    aud_rx_zero #(.WORD(WORD), .ZERO_RUN(ZERO_RUN)) u_zero (
        .clk_i   (bclk_i),
        .rst_ni  (rst_ni),
        .done_i  (slot_done),
        .left_i  (slot_left),
        .word_i  (slot_word),
        .zero_o  (zero_o)
    );

    AST_ZERO_WITH_VALID: assert property (@(posedge bclk_i) disable iff (!rst_ni)
        $rose(zero_o) |-> valid_o); // R7
    AST_RESET_QUIET: assert property (@(posedge bclk_i)
        !rst_ni |-> (!valid_o && !zero_o && left_o == '0 && right_o == '0)); // R9

endmodule

// File: tb/test_aud_rx.sv
`timescale 1ns/1ps
module test_aud_rx;

    localparam int W   = 24;
    localparam int RUN = 4;

    typedef struct packed {
        logic         fmt;
        logic [7:0]   len;
        logic [W-1:0] l;
        logic [W-1:0] r;
    } vec_t;

    localparam vec_t VT [8] = '{
        '{1'b0, 8'd32, 24'h123456, 24'h89ABCD},
        '{1'b0, 8'd24, 24'h7FFFFF, 24'h800000},
        '{1'b0, 8'd48, 24'hA5A5A5, 24'h5A5A5A},
        '{1'b0, 8'd20, 24'hFFFFFF, 24'h0F0F0F},
        '{1'b1, 8'd32, 24'h123456, 24'hFEDCBA},
        '{1'b1, 8'd24, 24'hC00001, 24'h000003},
        '{1'b1, 8'd20, 24'hFFFFFF, 24'hABCDEF},
        '{1'b1, 8'd40, 24'h000001, 24'h800000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fmt = 1'b0;
    logic frame = 1'b0;
    logic sdata = 1'b0;
    logic [W-1:0] lo, ro;
    logic vo, zo;

    always #4 clk = ~clk;

    aud_rx #(.WORD(W), .ZERO_RUN(RUN)) i_aud_rx (
        .bclk_i(clk), .rst_ni(rst_n), .fmt_i(fmt), .frame_i(frame), .sdata_i(sdata),
        .left_o(lo), .right_o(ro), .valid_o(vo), .zero_o(zo)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic pend = 1'b1;
    logic s_v, s_z, s_v2;
    logic [W-1:0] s_l, s_r;

    task automatic chk(input string req, input string what,
                       input logic [W-1:0] got, input logic [W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic drive(input logic f, input logic d);
        @(negedge clk);
        frame = f;
        sdata = d;
    endtask

    // one channel slot; snapshots taken just after its first two edges
    task automatic slot(input logic f, input logic [W-1:0] w, input int len);
        s_v2 = 1'b0;
        for (int k = 0; k < len; k++) begin
            int j;
            logic d;
            j = k - int'(fmt);
            if (fmt && k == 0) d = pend;
            else if (j < W) d = w[W-1-j];
            else d = 1'b1;
            drive(f, d);
            if (k < 2) begin
                @(posedge clk);
                #2;
                if (k == 0) begin
                    s_v = vo; s_z = zo; s_l = lo; s_r = ro;
                end else begin
                    s_v2 = vo;
                end
            end
        end
        pend = (len - 1 < W) ? w[W-len] : 1'b1;
    endtask

    function automatic logic [W-1:0] masked(input logic [W-1:0] w, input int len);
        int n;
        logic [W-1:0] m;
        n = (len < W) ? len : W;
        m = {W{1'b1}} << (W - n);
        return w & m;
    endfunction

    task automatic do_reset(input logic f);
        @(negedge clk);
        rst_n = 1'b0;
        fmt = f;
        frame = f;
        sdata = 1'b1;
        #1;
        chk("R9", "reset left", lo, '0);
        chk("R9", "reset right", ro, '0);
        chk("R9", "reset valid", W'(vo), '0);
        chk("R9", "reset zero", W'(zo), '0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        pend = 1'b1;
        drive(f, 1'b1);
        drive(f, 1'b0);
    endtask

    task automatic chk_emit(input string req, input logic [W-1:0] el, input logic [W-1:0] er);
        chk("R5", "strobe at boundary", W'(s_v), W'(1));
        chk("R5", "strobe one cycle", W'(s_v2), '0);
        chk(req, "left word", s_l, el);
        chk(req, "right word", s_r, er);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic have;
        logic lv;
        logic [W-1:0] el, er;
        string req;
        have = 1'b0;
        el = '0;
        er = '0;
        lv = 1'b1;
        // table walk (R1 R2 R3 R4 R6 R10)
        for (int i = 0; i < 8; i++) begin
            vec_t v;
            v = VT[i];
            if (i == 0 || v.fmt != VT[i-1].fmt) begin
                if (have) begin
                    slot(lv, '0, 2);
                    chk_emit(req, el, er);
                end
                do_reset(v.fmt);
                have = 1'b0;
            end
            lv = ~v.fmt;
            slot(lv, v.l, int'(v.len));
            if (have) chk_emit(req, el, er);
            else chk("R9", "no strobe for partial slot", W'(s_v), '0);
            slot(~lv, v.r, int'(v.len));
            chk("R5", "no strobe after left slot", W'(s_v), '0);
            chk("R5", "left output held", s_l, have ? el : '0);
            req = v.fmt ? "R3/R1" : "R2/R1";
            if (v.len < 8'd24) req = {req, "/R6"};
            if (v.len > 8'd24) req = {req, "/R4/R10"};
            el = masked(v.l, int'(v.len));
            er = masked(v.r, int'(v.len));
            have = 1'b1;
        end
        slot(lv, '0, 2);
        chk_emit(req, el, er);

        // silence monitor: R7 and R8
        do_reset(1'b0);
        for (int p = 0; p < RUN; p++) begin
            slot(1'b1, '0, 24);
            if (p > 0) chk("R7", "flag below run", W'(s_z), '0);
            slot(1'b0, '0, 24);
        end
        slot(1'b1, 24'h000001, 24);
        chk("R7", "strobe with flag rise", W'(s_v), W'(1));
        chk("R7", "flag at run", W'(s_z), W'(1));
        slot(1'b0, '0, 24);
        chk("R8", "flag drop on nonzero left", W'(s_z), '0);
        chk("R8", "no strobe at left close", W'(s_v), '0);
        for (int p = 0; p < RUN; p++) begin
            slot(1'b1, '0, 24);
            chk("R7", "flag low while rebuilding", W'(s_z), '0);
            slot(1'b0, '0, 24);
        end
        slot(1'b1, '0, 24);
        chk("R7", "flag rise second run", W'(s_z), W'(1));
        slot(1'b0, 24'h000005, 24);
        chk("R8", "zero left keeps flag", W'(s_z), W'(1));
        slot(1'b1, '0, 2);
        chk("R8", "strobe with flag drop", W'(s_v), W'(1));
        chk("R8", "flag drop on nonzero right", W'(s_z), '0);
        chk("R8", "right word", s_r, 24'h000005);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule